// File: doc/BRIEF.md
# Parallel-Output Converter Conversion Controller

This block is the digital control front end of a 16-bit converter with a parallel result port. The analog core is replaced by a sample word from the surrounding logic and a conversion that lasts a fixed number of clock cycles. Two active-low control inputs, a chip select and a read/convert-bar line, decide when a conversion starts and when the result bus is driven. Both inputs are first brought into the clock domain. Their synchronised forms are combined as levels, not edges, so a conversion starts whenever both are low and the converter is idle.

While a conversion runs, the BUSY output is low and further convert requests have no effect. The output register takes the new result on the same clock edge that BUSY returns high. The tri-state data bus is modelled as a data word plus an output enable. The bus is enabled only while chip select is low and read/convert-bar is high. During a conversion it carries the previous result; once BUSY is high it carries the new one.

If both controls are still low when BUSY returns high, a new conversion starts at once with no time to acquire a new signal. That result is marked by an invalid flag, which is updated together with the result register.

Top module: `conv_ctrl_top`

## Requirements
- R1: A conversion starts only when the synchronised chip select and read/convert-bar are both low while BUSY is high. BUSY falls SYNC_STAGES+1 clock edges after both inputs go low.
- R2: BUSY stays low for exactly CONV_CYCLES clock cycles per conversion.
- R3: Convert requests made while BUSY is low are ignored. BUSY is not lengthened, result_q does not change, and the result comes from the sample word captured on the edge that started the conversion.
- R4: If both controls are still low when BUSY rises, BUSY stays high for exactly one cycle and a new conversion starts. Its result is reported with result_invalid = 1. A conversion started after at least two idle cycles reports result_invalid = 0.
- R5: bus_oe is 0 whenever the synchronised chip select is high or the synchronised read/convert-bar is low. While bus_oe is 0, bus_data is all zeros.
- R6: With chip select low and read/convert-bar high, bus_oe is 1 and bus_data equals result_q. During a conversion this is the previous result.
- R7: Coding is straight binary. Bit i of result_q equals bit i of the captured sample, with bit DATA_W-1 (D15 by default) as the MSB.
- R8: result_q and result_invalid change only on the clock edge where BUSY rises, and the new values are visible in the same cycle as BUSY high.
- R9: After reset, busy = 1, result_q = 0, result_invalid = 0 and bus_oe = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rdconv_n | input | 1 | Read (high) / convert (low) control, asynchronous |
| sample_in | input | DATA_W | Sample word standing in for the analog input |
| busy | output | 1 | Low while a conversion runs |
| result_q | output | DATA_W | Output register, straight binary |
| result_invalid | output | 1 | Set for a result started without acquisition time |
| bus_data | output | DATA_W | Data bus value, zero when not driven |
| bus_oe | output | 1 | Bus output enable; 0 models high impedance |

## Verification
The bench builds the block with DATA_W = 16, CONV_CYCLES = 6 and SYNC_STAGES = 2. With a short conversion, the bench can poke the controls during BUSY and still release them before the end of the conversion, so ignored requests and back-to-back restarts are both reached in a few dozen cycles. With two synchronizer stages, the enable and start latencies are exact cycle counts that the bench predicts. The 16-bit width lets corner words such as the lone MSB, the lone LSB and all ones show the straight binary bit placement.

// File: rtl/conv_pkg.sv
package conv_pkg;

  // Width of a down-counter that must hold n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Bus is driven only while selected and in read phase (both active low inputs).
  function automatic logic bus_enable(input logic cs_n, input logic rdconv_n);
    return (~cs_n) & rdconv_n;
  endfunction

  // Level request: both controls low.
  function automatic logic convert_request(input logic cs_n, input logic rdconv_n);
    return ~(cs_n | rdconv_n);
  endfunction

endpackage

// File: rtl/cc_sync.sv
module cc_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= {WIDTH{RST_VAL}};
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= {WIDTH{RST_VAL}};
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cc_sequencer.sv
module cc_sequencer #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_both_low,
  input  logic [DATA_W-1:0] sample_in,
  output logic              busy,
  output logic              start_evt,
  output logic              finish_evt,
  output logic [DATA_W-1:0] held_sample,
  output logic              held_invalid
);
  import conv_pkg::*;
  localparam int unsigned CNT_W = cnt_width(CONV_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fresh_q;   // high in the cycle right after BUSY rose

  assign start_evt  = busy_q & req_both_low;
  assign finish_evt = ~busy_q & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b1;
      cnt_q        <= '0;
      fresh_q      <= 1'b0;
      held_sample  <= '0;
      held_invalid <= 1'b0;
    end else begin
      fresh_q <= finish_evt;
      if (start_evt) begin
        busy_q       <= 1'b0;
        cnt_q        <= CNT_LOAD;
        held_sample  <= sample_in;
        held_invalid <= fresh_q;
      end else if (!busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b1;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/cc_result.sv
module cc_result #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] held_sample,
  input  logic              held_invalid,
  output logic [DATA_W-1:0] result_q,
  output logic              result_invalid
);
  // Straight binary: bit i of the code is bit i of the sample, MSB on top.
  function automatic logic [DATA_W-1:0] code_word(input logic [DATA_W-1:0] s);
    logic [DATA_W-1:0] c;
    for (int i = 0; i < int'(DATA_W); i++) c[i] = s[i];
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q       <= '0;
      result_invalid <= 1'b0;
    end else if (load) begin
      result_q       <= code_word(held_sample);
      result_invalid <= held_invalid;
    end
  end
endmodule

// File: rtl/cc_bus.sv
module cc_bus #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              cs_n_s,
  input  logic              rdconv_n_s,
  input  logic [DATA_W-1:0] result_q,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_oe
);
  import conv_pkg::*;
  always_comb begin
    bus_oe   = bus_enable(cs_n_s, rdconv_n_s);
    bus_data = bus_oe ? result_q : '0;
  end
endmodule

// File: rtl/conv_ctrl_top.sv
module conv_ctrl_top #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rdconv_n,
  input  logic [DATA_W-1:0] sample_in,
  output logic              busy,
  output logic [DATA_W-1:0] result_q,
  output logic              result_invalid,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_oe
);
  import conv_pkg::*;

  logic [1:0]        ctl_s;
  wire               cs_n_s     = ctl_s[1];
  wire               rdconv_n_s = ctl_s[0];
  wire               req_both_low = convert_request(cs_n_s, rdconv_n_s);
  logic              start_evt, finish_evt;
  logic [DATA_W-1:0] held_sample;
  logic              held_invalid;

  cc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, rdconv_n}), .q(ctl_s)
  );

  cc_sequencer #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_both_low(req_both_low), .sample_in(sample_in),
    .busy(busy), .start_evt(start_evt), .finish_evt(finish_evt),
    .held_sample(held_sample), .held_invalid(held_invalid)
  );

  cc_result #(.DATA_W(DATA_W)) u_res (
    .clk(clk), .rst_n(rst_n), .load(finish_evt), .held_sample(held_sample),
    .held_invalid(held_invalid), .result_q(result_q), .result_invalid(result_invalid)
  );

  cc_bus #(.DATA_W(DATA_W)) u_bus (
    .cs_n_s(cs_n_s), .rdconv_n_s(rdconv_n_s), .result_q(result_q),
    .bus_data(bus_data), .bus_oe(bus_oe)
  );
endmodule

// File: rtl/conv_ctrl_chk.sv
module conv_ctrl_chk #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              req_both_low,
  input logic [DATA_W-1:0] result_q,
  input logic              result_invalid,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_oe
);
  int unsigned low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_cnt <= 0;
    else if (!busy) low_cnt <= low_cnt + 1;
    else            low_cnt <= 0;
  end

  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(req_both_low)); // R1
  AST_IDLE_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_both_low) |=> !busy); // R1
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (low_cnt == CONV_CYCLES)); // R2
  AST_RESULT_HELD_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> $stable(result_q)); // R3
  AST_RESTART_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && req_both_low) |=> !busy); // R4
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_data == '0)); // R5
  AST_BUS_CARRIES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_data == result_q)); // R6
  AST_LOAD_ONLY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(result_q) && $stable(result_invalid))); // R8
endmodule

bind conv_ctrl_top conv_ctrl_chk #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .req_both_low(req_both_low),
  .result_q(result_q), .result_invalid(result_invalid),
  .bus_data(bus_data), .bus_oe(bus_oe)
);

// File: tb/sim_conv_ctrl_top.sv
module sim_conv_ctrl_top;
  localparam int unsigned DW = 16;
  localparam int unsigned NC = 6;
  localparam int unsigned NS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rdconv_n = 1'b1;
  logic [DW-1:0] sample_in = '0;
  logic busy, result_invalid, bus_oe;
  logic [DW-1:0] result_q, bus_data;

  always #4 clk = ~clk;  // 125 MHz

  conv_ctrl_top #(.DATA_W(DW), .CONV_CYCLES(NC), .SYNC_STAGES(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rdconv_n(rdconv_n), .sample_in(sample_in),
    .busy(busy), .result_q(result_q), .result_invalid(result_invalid),
    .bus_data(bus_data), .bus_oe(bus_oe)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] last_res = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Bench view of the bus, from the requirements.
  function automatic logic [DW-1:0] exp_bus(input logic cs, input logic rc, input logic [DW-1:0] r);
    return (!cs && rc) ? r : '0;
  endfunction

  // Bench view of straight binary coding: bit-by-bit from MSB down.
  function automatic logic [DW-1:0] exp_code(input logic [DW-1:0] s);
    logic [DW-1:0] c = '0;
    for (int i = DW - 1; i >= 0; i--) c = (c << 1) | DW'(s[i]);
    return c;
  endfunction

  // One normal conversion; poke toggles the convert line during BUSY.
  task automatic convert(input logic [DW-1:0] v, input bit poke);
    int lat = 0;
    int len = 0;
    @(negedge clk);
    sample_in = v; cs_n = 1'b0; rdconv_n = 1'b0;
    while (busy && lat < 50) begin @(negedge clk); lat++; end
    chk("R1 start latency", 64'(lat), 64'(NS + 1));
    chk("R5 bus off while convert low", 64'({bus_oe, bus_data}), 64'(0));
    rdconv_n = 1'b1;
    sample_in = ~v;  // later sample words must not reach the result
    while (!busy && len < 50) begin
      @(negedge clk); len++;
      if (poke && len == 1) rdconv_n = 1'b0;
      if (poke && len == 2) rdconv_n = 1'b1;
      if (len == int'(NC) - 1) begin
        chk("R6 bus enabled during conversion", 64'(bus_oe), 64'(1));
        chk("R6 previous result on bus", 64'(bus_data), 64'(last_res));
        chk("R3 result unchanged while busy", 64'(result_q), 64'(last_res));
      end
    end
    chk(poke ? "R3 busy not lengthened by request" : "R2 busy length", 64'(len), 64'(NC));
    chk("R7 straight binary result", 64'(result_q), 64'(exp_code(v)));
    chk("R8 result with busy high", 64'(result_invalid), 64'(0));
    chk("R6 new result on bus", 64'(bus_data), 64'(exp_bus(1'b0, 1'b1, exp_code(v))));
    last_res = exp_code(v);
    cs_n = 1'b1;
    repeat (NS + 1) @(negedge clk);
    chk("R5 bus off when deselected", 64'({bus_oe, bus_data}), 64'(0));
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset busy", 64'(busy), 64'(1));
    chk("R9 reset result", 64'(result_q), 64'(0));
    chk("R9 reset invalid", 64'(result_invalid), 64'(0));
    chk("R9 reset bus", 64'(bus_oe), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Idle with only one control low: no conversion, bus per R5/R6.
    cs_n = 1'b0; rdconv_n = 1'b1;
    repeat (NS + 3) @(negedge clk);
    chk("R1 no start on read phase", 64'(busy), 64'(1));
    chk("R6 idle read", 64'(bus_data), 64'(exp_bus(1'b0, 1'b1, last_res)));
    cs_n = 1'b1; rdconv_n = 1'b0;
    repeat (NS + 3) @(negedge clk);
    chk("R1 no start when deselected", 64'(busy), 64'(1));
    chk("R5 deselected bus", 64'(bus_oe), 64'(0));
    rdconv_n = 1'b1;
    repeat (NS + 1) @(negedge clk);

    // Directed corner words for R7.
    convert(16'h8000, 1'b0);
    convert(16'h0001, 1'b0);
    convert(16'hFFFF, 1'b0);
    convert(16'h1234, 1'b1);

    // Back-to-back restart (R4).
    begin
      int n = 0;
      @(negedge clk);
      sample_in = 16'hA5C3; cs_n = 1'b0; rdconv_n = 1'b0;
      while (busy && n < 50) begin @(negedge clk); n++; end
      n = 0;
      while (!busy && n < 50) begin @(negedge clk); n++; end
      chk("R4 first result", 64'(result_q), 64'(exp_code(16'hA5C3)));
      chk("R4 first result valid", 64'(result_invalid), 64'(0));
      sample_in = 16'h5A3C;
      @(negedge clk);
      chk("R4 busy high one cycle then restart", 64'(busy), 64'(0));
      rdconv_n = 1'b1;
      n = 0;
      while (!busy && n < 50) begin @(negedge clk); n++; end
      chk("R4 restart busy length", 64'(n), 64'(NC));
      chk("R4 restarted result", 64'(result_q), 64'(exp_code(16'h5A3C)));
      chk("R4 restart flagged invalid", 64'(result_invalid), 64'(1));
      last_res = exp_code(16'h5A3C);
      cs_n = 1'b1;
      repeat (NS + 2) @(negedge clk);
    end
    convert(16'h0F0F, 1'b0);

    // Constrained random conversions.
    void'($urandom(32'd1357));
    for (int k = 0; k < 40; k++) begin
      logic [DW-1:0] v = DW'($urandom);
      bit p = bit'($urandom_range(0, 1));
      convert(v, p);
      repeat ($urandom_range(0, 4)) @(negedge clk);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule